// File: doc/BRIEF.md
# Oscillator-Halt and Supply-Drop Status Flags

This block holds two sticky status bits for a real-time-clock register file. One bit records that the 32.768 kHz timebase stopped running. The other records that the supply comparator reported a voltage below the selected threshold. Each bit is set by hardware when its condition is seen. Only software can return it to zero, by writing 0 to that bit. Writing 1 leaves the bit as it is.

The oscillator clock and the comparator output arrive as asynchronous digital levels. The block synchronizes both to the system clock. A halt is declared when no rising oscillator edge is seen for `HALT_LIMIT` system cycles. This watch runs only while the chip-enable pin is low.

A halt event (a timeout or a power-up indication) sets the halt bit and forces the supply-drop bit to zero. It also raises `clr_ctrl_o` for one cycle. The surrounding register file uses that strobe to zero its control group: oscillator trim, alarm enables, hour-format select, clock-output enables, test bit, periodic-interrupt select, threshold select, scratch bits and interrupt flags. The status pair `{halt, drop}` reads as follows:
- 00: no event.
- 01: supply drop only.
- 1x: halt; the drop bit is then meaningless.

Top module: `rtc_health_flags`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `status_o` is 2'b10 (bit 1 = halt, bit 0 = supply drop) and `clr_ctrl_o` is 0. The halt watch starts disarmed.
- R2: `por_i` high at a clock edge makes `status_o` 2'b10 and `clr_ctrl_o` 1 after that edge.
- R3: The watch counts system cycles while armed and resets its count on every rising edge of the synchronized oscillator. The oscillator passes through a two-flop synchronizer, plus one more flop for edge detection. After `HALT_LIMIT` counted cycles with no edge, the halt bit sets once.
- R4: The watch is armed only while `ce_i` is low, seen through a two-flop synchronizer. A high level clears the count and blocks detection. A halt bit already set stays set.
- R5: `vlow_i` goes through a two-flop synchronizer. The drop bit sets only when two consecutive synchronized samples are high, so it sets on the fourth edge after `vlow_i` rises. A one-cycle pulse never sets it.
- R6: A write with `wr_en_i` high clears each status bit whose `wr_data_i` bit is 0 (bit 1 halt, bit 0 drop). A bit written with 1 keeps its value. Without a write, both bits hold.
- R7: Every halt event forces the drop bit to 0. It also drives `clr_ctrl_o` high for the next cycle only. In all other cycles `clr_ctrl_o` is 0.
- R8: The drop bit cannot set in a cycle where the halt bit is 1.
- R9: When a detection event and a write of 0 to the same bit fall in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_clk_i | input | 1 | 32.768 kHz oscillator, sampled as data |
| ce_i | input | 1 | Chip-enable pin level |
| por_i | input | 1 | Power-up-from-zero indication, synchronous to clk_i |
| vlow_i | input | 1 | Supply-below-threshold comparator output |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 2 | Write data: bit 1 halt, bit 0 drop; 0 clears |
| status_o | output | 2 | {halt, drop} flags |
| clr_ctrl_o | output | 1 | One-cycle clear strobe for the control group |

## Verification
The assertions take `por_i`, `wr_en_i` and `wr_data_i` to be synchronous to `clk_i`. They also assume that any asynchronous input changes at most once per sampling window, so the synchronizer outputs follow the pin with a fixed two-cycle delay. The stimulus drives every input at the falling edge of the system clock. It moves the oscillator in steps of whole system cycles and keeps its half period at four cycles. All flag timing is therefore fixed to the cycle and can be predicted exactly.

// File: rtl/rtc_hf_pkg.sv
package rtc_hf_pkg;
  localparam int unsigned ST_HALT_BIT  = 1;
  localparam int unsigned ST_BROWN_BIT = 0;

  typedef struct packed {
    logic halt;
    logic brown;
  } stat_t;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rtc_halt_det.sv
module rtc_halt_det #(
  parameter int unsigned HALT_LIMIT = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  input  logic ce_i,
  output logic halt_evt_o
);
  localparam int unsigned CW = $clog2(HALT_LIMIT + 1);
  localparam logic [CW-1:0] LIM     = CW'(HALT_LIMIT);
  localparam logic [CW-1:0] LIM_M1  = CW'(HALT_LIMIT - 1);

  logic          osc_s, osc_d, ce_s, armed, rise;
  logic [CW-1:0] cnt_q;

  rtc_sync #(.W(1), .RST_VAL(1'b0)) i_osc_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(osc_i), .q_o(osc_s));
  // ce sync resets high: watch is disarmed out of reset
  rtc_sync #(.W(1), .RST_VAL(1'b1)) i_ce_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ce_i), .q_o(ce_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_d <= 1'b0;
    else         osc_d <= osc_s;
  end

  assign armed = ~ce_s;
  assign rise  = osc_s & ~osc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!armed || rise)  cnt_q <= '0;
    else if (cnt_q != LIM)    cnt_q <= cnt_q + 1'b1;
  end

  // fires once on reaching the limit; counter then saturates
  assign halt_evt_o = armed && !rise && (cnt_q == LIM_M1);

  AST_DISARM_CLEARS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> (cnt_q == '0)); // R4
  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM); // R3
  AST_EDGE_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/rtc_brown_qual.sv
module rtc_brown_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vlow_i,
  output logic bo_evt_o
);
  logic v_s, v_d;

  rtc_sync #(.W(1), .RST_VAL(1'b0)) i_vlow_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vlow_i), .q_o(v_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_d <= 1'b0;
    else         v_d <= v_s;
  end

  assign bo_evt_o = v_s & v_d;

  AST_TWO_SAMPLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_evt_o |-> $past(v_s)); // R5
endmodule

// File: rtl/rtc_health_flags.sv
module rtc_health_flags
  import rtc_hf_pkg::*;
#(
  parameter int unsigned HALT_LIMIT = 8192
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_clk_i,
  input  logic       ce_i,
  input  logic       por_i,
  input  logic       vlow_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  output logic [1:0] status_o,
  output logic       clr_ctrl_o
);
  stat_t stat_q;
  logic  clr_q, halt_evt, bo_evt, halt_set, wr_clr_halt, wr_clr_brown;

  rtc_halt_det #(.HALT_LIMIT(HALT_LIMIT)) i_halt_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_i(osc_clk_i), .ce_i(ce_i),
    .halt_evt_o(halt_evt));

  rtc_brown_qual i_brown_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .vlow_i(vlow_i), .bo_evt_o(bo_evt));

  assign halt_set     = halt_evt | por_i;
  assign wr_clr_halt  = wr_en_i & ~wr_data_i[ST_HALT_BIT];
  assign wr_clr_brown = wr_en_i & ~wr_data_i[ST_BROWN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '{halt: 1'b1, brown: 1'b0};
      clr_q  <= 1'b0;
    end else begin
      clr_q <= halt_set;
      // detection takes priority over a software clear
      if (halt_set)         stat_q.halt <= 1'b1;
      else if (wr_clr_halt) stat_q.halt <= 1'b0;
      if (halt_set)                      stat_q.brown <= 1'b0;
      else if (bo_evt && !stat_q.halt)   stat_q.brown <= 1'b1;
      else if (wr_clr_brown)             stat_q.brown <= 1'b0;
    end
  end

  assign status_o[ST_HALT_BIT]  = stat_q.halt;
  assign status_o[ST_BROWN_BIT] = stat_q.brown;
  assign clr_ctrl_o             = clr_q;

  AST_HALT_MASKS_BROWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q.halt |-> !stat_q.brown); // R8
  AST_CLR_WITH_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> stat_q.halt); // R7
  AST_POR_SETS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (stat_q.halt && !stat_q.brown && clr_q)); // R2
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q.halt && !(wr_en_i && !wr_data_i[ST_HALT_BIT])) |=> stat_q.halt); // R6
  AST_BROWN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q.brown && !halt_evt && !por_i && !(wr_en_i && !wr_data_i[ST_BROWN_BIT]))
      |=> stat_q.brown); // R6
  AST_DETECT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i && wr_en_i) |=> stat_q.halt); // R9
endmodule

// File: tb/test_rtc_health_flags.sv
module test_rtc_health_flags;
  localparam int LIM = 20;
  localparam int OSC_HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc = 1'b0, ce = 1'b1, por = 1'b0, vlow = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_data = 2'b11;
  logic [1:0] status;
  logic clr;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit osc_run = 1'b0;
  int osc_ph = 0;

  always #5 clk = ~clk;

  rtc_health_flags #(.HALT_LIMIT(LIM)) i_rtc_health_flags (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc), .ce_i(ce), .por_i(por),
    .vlow_i(vlow), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .status_o(status), .clr_ctrl_o(clr));

  // reference model built from the requirements
  logic m_os1, m_os2, m_os3, m_ce1, m_ce2, m_v1, m_v2, m_v3, m_halt, m_bo, m_clr;
  int   m_cnt;

  function automatic logic [1:0] next_flags(input logic halt, input logic bo,
      input logic hset, input logic bevt, input logic we, input logic [1:0] wd);
    logic nh, nb;
    nh = hset ? 1'b1 : ((we && !wd[1]) ? 1'b0 : halt);
    if (hset)              nb = 1'b0;
    else if (bevt && !halt) nb = 1'b1;
    else if (we && !wd[0]) nb = 1'b0;
    else                   nb = bo;
    return {nh, nb};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_os1, m_os2, m_os3} = 3'b000;
      {m_ce1, m_ce2} = 2'b11;
      {m_v1, m_v2, m_v3} = 3'b000;
      m_cnt = 0; m_halt = 1'b1; m_bo = 1'b0; m_clr = 1'b0;
    end else begin
      logic rise, armed, hevt, bevt, hset;
      logic [1:0] nf;
      rise  = m_os2 & ~m_os3;
      armed = ~m_ce2;
      hevt  = armed && !rise && (m_cnt == LIM - 1);
      bevt  = m_v2 && m_v3;
      hset  = hevt || por;
      nf = next_flags(m_halt, m_bo, hset, bevt, wr_en, wr_data);
      m_halt = nf[1]; m_bo = nf[0]; m_clr = hset;
      if (!armed || rise) m_cnt = 0;
      else if (m_cnt != LIM) m_cnt = m_cnt + 1;
      m_os3 = m_os2; m_os2 = m_os1; m_os1 = osc;
      m_ce2 = m_ce1; m_ce1 = ce;
      m_v3 = m_v2; m_v2 = m_v1; m_v1 = vlow;
    end
  end

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {status,clr} actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) check(cur_req, {status, clr}, {m_halt, m_bo, m_clr});
  end

  always @(negedge clk) begin
    if (osc_run) begin
      osc_ph++;
      if (osc_ph >= OSC_HALF) begin osc_ph = 0; osc = ~osc; end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] d);
    wr_en = 1'b1; wr_data = d; cyc(1); wr_en = 1'b0; wr_data = 2'b11;
  endtask

  initial begin
    fork
      begin
        cyc(3);
        check("R1", {status, clr}, 3'b100);  // during reset
        rst_n = 1'b1;
        cyc(1);
        check("R1", {status, clr}, 3'b100);
        cur_req = "R1"; cyc(5);

        cur_req = "R6"; wr(2'b11); cyc(2);
        check("R6", {status, clr}, 3'b100);
        wr(2'b01); cyc(1);
        check("R6", {status, clr}, 3'b000);

        cur_req = "R5"; vlow = 1'b1; cyc(1); vlow = 1'b0; cyc(6);
        check("R5", {status, clr}, 3'b000);
        vlow = 1'b1; cyc(3);
        check("R5", {status, clr}, 3'b000);
        cyc(1);
        check("R5", {status, clr}, 3'b010);
        vlow = 1'b0; cyc(4);
        cur_req = "R6"; wr(2'b10); cyc(1);
        check("R6", {status, clr}, 3'b000);

        cur_req = "R3"; osc_run = 1'b1; ce = 1'b0; cyc(120);
        check("R3", {status, clr}, 3'b000);
        osc_run = 1'b0; cur_req = "R7"; cyc(LIM + 8);
        check("R3", status, 2'b10);

        cur_req = "R8"; vlow = 1'b1; cyc(10);
        check("R8", {status, clr}, 3'b100);
        wr(2'b01); cyc(5);
        check("R8", status, 2'b01);
        vlow = 1'b0; cyc(4); wr(2'b10);

        cur_req = "R4"; ce = 1'b1; cyc(LIM * 3);
        check("R4", status, 2'b00);
        ce = 1'b0; osc_run = 1'b1; cyc(50); ce = 1'b1; cyc(4); osc_run = 1'b0; cyc(40);
        check("R4", status, 2'b00);

        cur_req = "R2"; por = 1'b1; cyc(1); por = 1'b0;
        check("R2", {status, clr}, 3'b101);
        cyc(1);
        check("R7", clr, 1'b0);

        cur_req = "R9"; por = 1'b1; wr_en = 1'b1; wr_data = 2'b00; cyc(1);
        por = 1'b0; wr_en = 1'b0; wr_data = 2'b11;
        check("R9", status[1], 1'b1);
        wr(2'b01);
        vlow = 1'b1; cyc(6);
        wr_en = 1'b1; wr_data = 2'b10; cyc(1); wr_en = 1'b0; wr_data = 2'b11;
        check("R9", status[0], 1'b1);
        vlow = 1'b0; cyc(4);

        cur_req = "R3";
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 6000; i++) begin
          if ($urandom_range(59) == 0) ce = ~ce;
          if ($urandom_range(79) == 0) osc_run = ~osc_run;
          if ($urandom_range(19) == 0) vlow = ~vlow;
          por = ($urandom_range(699) == 0);
          wr_en = ($urandom_range(9) == 0);
          wr_data = 2'($urandom_range(3));
          cyc(1);
        end
        por = 1'b0; wr_en = 1'b0;
        cyc(2);
      end
      begin
        cyc(150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule